// File: doc/BRIEF.md
# Asynchronous Character Receiver with Address Interrupt

This block is the receive side of an asynchronous serial port. It watches a single serial input line, sampled through a two-stage synchronizer, and is paced by a one-clock enable pulse that arrives sixteen times per bit period. It detects a start bit and confirms it at mid-bit. It then collects five to eight data bits, least significant first, an optional ninth bit, and one or two stop bits. At the end of each frame it loads a receive buffer and issues one-clock status pulses.

Software sets a two-bit address mode and an 8-bit compare value. Together these pick one of four conditions that raise an address interrupt. The interrupt can fire on a set ninth bit, on a character that equals the compare value, on both at once, or on a matching character that is the first one after a line break. This lets a node on a shared line ignore traffic until it is addressed, or lets software search a stream for a delimiter character.

The configuration inputs must be held stable while a frame is in progress.

Top module: `async_rx_addr`

## Requirements
- R1: In idle, a tick that finds the synchronized line low starts a frame. If the line is high again on the eighth tick after that detection, the start is treated as noise: no status pulse is produced and the receiver returns to idle.
- R2: After a confirmed start, every further bit is sampled 16 ticks after the previous one. On the clock edge that samples the last stop bit, `rx_data`/`rx_ninth` are loaded and `rx_ready` pulses for exactly one clock. At all other times the buffer holds its value.
- R3: `wlen_sel` selects 5 + `wlen_sel` data bits (0→5, 1→6, 2→7, 3→8). Buffer bits above the word length read as 1.
- R4: With `nine_en` high, one extra bit follows the data bits and is presented on `rx_ninth`. With `nine_en` low, no such bit is received and `rx_ninth` is loaded with 0.
- R5: `two_stop` selects one (0) or two (1) stop bits. If any stop bit is sampled low in a frame that is not a break, `frm_err` pulses together with `rx_ready`.
- R6: A frame whose start, data, ninth and stop samples are all low is a break. It pulses `brk_det`, produces no `rx_ready`, and leaves the buffer unchanged. After any frame whose last stop bit is low, no new start is accepted until the line has been seen high.
- R7: Address mode `amode`=0: `addr_irq` pulses with `rx_ready` when the received ninth bit is 1.
- R8: Address mode 1: `addr_irq` pulses with `rx_ready` when the 8-bit buffer value (upper bits padded with ones) equals `cmp_val`. The ninth bit is not part of the comparison.
- R9: Address mode 2: `addr_irq` pulses when the buffer value equals `cmp_val` and the ninth bit is 1.
- R10: Address mode 3: a break arms the condition. The next non-break character disarms it, and that character raises `addr_irq` only if it equals `cmp_val`.
- R11: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 1 | Serial input line, idle high |
| tick16 | input | 1 | One-clock enable, 16 per bit period |
| wlen_sel | input | 2 | Data bits minus five |
| two_stop | input | 1 | 1 = two stop bits |
| nine_en | input | 1 | 1 = ninth bit present |
| amode | input | 2 | Address interrupt condition select |
| cmp_val | input | 8 | Address compare value |
| rx_data | output | 8 | Receive buffer |
| rx_ninth | output | 1 | Received ninth bit |
| rx_ready | output | 1 | One-clock pulse, character loaded |
| brk_det | output | 1 | One-clock pulse, break received |
| frm_err | output | 1 | One-clock pulse, stop bit low |
| addr_irq | output | 1 | One-clock pulse, address condition met |

## Verification
The assertions check properties on every cycle:
- a break never coincides with a loaded character;
- a framing error or an address interrupt always comes with a loaded character;
- the buffer holds between loads;
- the upper bits are padded for short words;
- an interrupt in each mode agrees with the ninth bit and the compare value on the ports.

Only the bench scenarios can show:
- the exact sampling instants;
- noise rejection;
- that a held-low line after a break gives one break and not a string of them;
- the arm-and-disarm sequence of mode 3 across several characters.

// File: rtl/async_rx_addr.sv
module async_rx_addr #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       tick16,
  input  logic [1:0] wlen_sel,
  input  logic       two_stop,
  input  logic       nine_en,
  input  logic [1:0] amode,
  input  logic [7:0] cmp_val,
  output logic [7:0] rx_data,
  output logic       rx_ninth,
  output logic       rx_ready,
  output logic       brk_det,
  output logic       frm_err,
  output logic       addr_irq
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS, S_HOLD} st_t;

  st_t         st;
  logic [1:0]  sy;
  logic [CW-1:0] cnt;
  logic [3:0]  idx;
  logic [7:0]  dat;
  logic        nin, seen_hi, stop_low, arm;

  wire        rx_s = sy[1];
  wire [3:0]  wl   = 4'd5 + {2'b00, wlen_sel};
  wire [3:0]  nsmp = wl + {3'b000, nine_en} + 4'd1 + {3'b000, two_stop};
  wire [7:0]  mask = ~(8'hFF << wl);
  wire [7:0]  padded = (dat & mask) | ~mask;
  wire        samp = tick16 && st == S_BITS && cnt == LAST;
  wire        fin  = samp && idx == nsmp - 4'd1;
  wire        fin_brk = fin && !seen_hi && !rx_s;
  wire        fin_chr = fin && !fin_brk;
  wire        match = padded == cmp_val;

  logic hit;
  always_comb begin
    case (amode)
      2'd0:    hit = nin;
      2'd1:    hit = match;
      2'd2:    hit = match && nin;
      default: hit = match && arm;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sy <= 2'b11;
    else        sy <= {sy[0], rxd};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; idx <= '0; dat <= '0;
      nin <= 1'b0; seen_hi <= 1'b0; stop_low <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (tick16 && !rx_s) begin
            st <= S_START; cnt <= '0;
          end
        S_START:
          if (tick16) begin
            if (cnt == MID) begin
              cnt <= '0;
              if (rx_s) st <= S_IDLE;
              else begin
                st <= S_BITS; idx <= '0; dat <= '0;
                nin <= 1'b0; seen_hi <= 1'b0; stop_low <= 1'b0;
              end
            end else cnt <= cnt + 1'b1;
          end
        S_BITS:
          if (tick16) begin
            if (cnt == LAST) begin
              cnt <= '0;
              idx <= idx + 4'd1;
              if (idx < wl)                  dat[idx[2:0]] <= rx_s;
              else if (nine_en && idx == wl) nin <= rx_s;
              else if (!rx_s)                stop_low <= 1'b1;
              if (rx_s) seen_hi <= 1'b1;
              if (fin) st <= rx_s ? S_IDLE : S_HOLD;
            end else cnt <= cnt + 1'b1;
          end
        default:
          if (rx_s) st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data <= '0; rx_ninth <= 1'b0; rx_ready <= 1'b0;
      brk_det <= 1'b0; frm_err <= 1'b0; addr_irq <= 1'b0; arm <= 1'b0;
    end else begin
      rx_ready <= fin_chr;
      brk_det  <= fin_brk;
      frm_err  <= fin_chr && (stop_low || !rx_s);
      addr_irq <= fin_chr && hit;
      if (fin_chr) begin
        rx_data  <= padded;
        rx_ninth <= nin;
      end
      if (fin_brk)      arm <= 1'b1;
      else if (fin_chr) arm <= 1'b0;
    end
  end

  p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |=> !rx_ready);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |-> $stable({rx_data, rx_ninth}));
  p_pad_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && wlen_sel == 2'd0) |-> (rx_data[7:5] == 3'b111));
  p_noninth_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && !nine_en) |-> !rx_ninth);
  p_ferr_char_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frm_err |-> rx_ready);
  p_brk_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(brk_det && rx_ready));
  p_mode0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_irq && amode == 2'd0) |-> rx_ninth);
  p_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_irq && amode != 2'd0) |-> (rx_data == cmp_val));
  p_mode2_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_irq && amode == 2'd2) |-> rx_ninth);
  p_irq_char_r10: assert property (@(posedge clk) disable iff (!rst_n)
    addr_irq |-> rx_ready);
endmodule

// File: tb/async_rx_addr_test.sv
module async_rx_addr_test;
  logic clk = 1'b0, rst_n = 1'b0, rxd = 1'b1, tick16 = 1'b0;
  logic [1:0] wlen_sel = 2'd3, amode = 2'd1;
  logic two_stop = 1'b0, nine_en = 1'b0;
  logic [7:0] cmp_val = 8'h00;
  logic [7:0] rx_data;
  logic rx_ninth, rx_ready, brk_det, frm_err, addr_irq;

  int vec = 0, bad = 0;
  bit done = 0, armed = 0;
  logic [7:0] e_data = 8'h00, f_data = 8'h00;
  logic e_nin = 1'b0, f_nin = 1'b0;
  logic f_rdy = 0, f_brk = 0, f_fe = 0, f_irq = 0;

  always #2 clk = ~clk;

  async_rx_addr uut (.clk(clk), .rst_n(rst_n), .rxd(rxd), .tick16(tick16),
    .wlen_sel(wlen_sel), .two_stop(two_stop), .nine_en(nine_en), .amode(amode),
    .cmp_val(cmp_val), .rx_data(rx_data), .rx_ninth(rx_ninth), .rx_ready(rx_ready),
    .brk_det(brk_det), .frm_err(frm_err), .addr_irq(addr_irq));

  task automatic chk(input string r, input string nm, input logic [7:0] act, input logic [7:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", r, nm, act, exp, $time);
    end
  endtask

  task automatic step(input logic tk, input logic d, input bit fire, input string r);
    tick16 = tk; rxd = d;
    @(negedge clk);
    if (fire && f_rdy) begin e_data = f_data; e_nin = f_nin; end
    chk(r, "rx_data", rx_data, e_data);
    chk(r, "rx_ninth", {7'd0, rx_ninth}, {7'd0, e_nin});
    chk(r, "rx_ready", {7'd0, rx_ready}, {7'd0, fire & f_rdy});
    chk(r, "brk_det", {7'd0, brk_det}, {7'd0, fire & f_brk});
    chk(r, "frm_err", {7'd0, frm_err}, {7'd0, fire & f_fe});
    chk(r, "addr_irq", {7'd0, addr_irq}, {7'd0, fire & f_irq});
  endtask

  task automatic tick_period(input logic d, input bit fire, input string r);
    step(1'b1, d, fire, r);
    for (int k = 0; k < 3; k++) step(1'b0, d, 1'b0, r);
  endtask

  task automatic idle(input int n, input logic lvl, input string r);
    for (int t = 0; t < n; t++) tick_period(lvl, 1'b0, r);
  endtask

  task automatic send(input logic [7:0] d, input logic n9, input logic s1, input logic s2, input string r);
    logic [15:0] fr;
    int wl, n;
    logic [7:0] mask, pad;
    bit brk, match;
    wl = 5 + int'(wlen_sel);
    mask = ~(8'hFF << wl);
    pad = (d & mask) | ~mask;
    fr = '0;
    for (int i = 0; i < wl; i++) fr[1 + i] = d[i];
    n = 1 + wl;
    if (nine_en) begin fr[n] = n9; n++; end
    fr[n] = s1; n++;
    if (two_stop) begin fr[n] = s2; n++; end
    brk = ((d & mask) == 0) && !(nine_en && n9) && !s1 && !(two_stop && s2);
    match = (pad == cmp_val);
    if (brk) begin
      f_rdy = 0; f_brk = 1; f_fe = 0; f_irq = 0; armed = 1;
    end else begin
      f_rdy = 1; f_brk = 0; f_data = pad; f_nin = nine_en ? n9 : 1'b0;
      f_fe = !s1 || (two_stop && !s2);
      case (amode)
        2'd0: f_irq = f_nin;
        2'd1: f_irq = match;
        2'd2: f_irq = match && f_nin;
        default: f_irq = match && armed;
      endcase
      armed = 0;
    end
    for (int t = 0; t < 16 * n; t++)
      tick_period(fr[t / 16], t == 16 * (n - 1) + 9, r);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) @(negedge clk);
    // R11: outputs during reset
    chk("R11", "rx_data", rx_data, 8'h00);
    chk("R11", "pulses", {4'd0, rx_ready, brk_det, frm_err, addr_irq}, 8'h00);
    chk("R11", "rx_ninth", {7'd0, rx_ninth}, 8'h00);
    rst_n = 1'b1;
    idle(4, 1'b1, "R11");

    // R2 / R8: 8-bit, one stop, compare mode
    wlen_sel = 2'd3; amode = 2'd1; cmp_val = 8'h3C;
    send(8'hA5, 0, 1, 1, "R2"); idle(6, 1'b1, "R2");
    send(8'h3C, 0, 1, 1, "R8"); idle(6, 1'b1, "R8");

    // R3: 5-bit word, padded compare
    wlen_sel = 2'd0; cmp_val = 8'hEA;
    send(8'h0A, 0, 1, 1, "R3"); idle(6, 1'b1, "R3");
    send(8'h15, 0, 1, 1, "R3"); idle(6, 1'b1, "R3");

    // R5: 7-bit word, two stop bits
    wlen_sel = 2'd2; two_stop = 1'b1;
    send(8'h55, 0, 1, 1, "R5"); idle(6, 1'b1, "R5");
    send(8'h41, 0, 0, 1, "R5"); idle(6, 1'b1, "R5");
    send(8'h22, 0, 1, 0, "R5"); idle(6, 1'b1, "R5");
    two_stop = 1'b0; wlen_sel = 2'd3;
    send(8'h77, 0, 0, 0, "R5"); idle(6, 1'b1, "R5");

    // R4 / R7: ninth bit, mode 0
    nine_en = 1'b1; amode = 2'd0;
    send(8'h10, 1, 1, 1, "R7"); idle(6, 1'b1, "R7");
    send(8'h10, 0, 1, 1, "R4"); idle(6, 1'b1, "R4");

    // R9: mode 2
    amode = 2'd2; cmp_val = 8'h80;
    send(8'h80, 1, 1, 1, "R9"); idle(6, 1'b1, "R9");
    send(8'h80, 0, 1, 1, "R9"); idle(6, 1'b1, "R9");
    send(8'h81, 1, 1, 1, "R9"); idle(6, 1'b1, "R9");
    nine_en = 1'b0;
    send(8'h80, 0, 1, 1, "R4"); idle(6, 1'b1, "R4");

    // R1: noise start
    for (int t = 0; t < 5; t++) tick_period(1'b0, 1'b0, "R1");
    idle(24, 1'b1, "R1");

    // R6 / R10: break and mode 3
    amode = 2'd3; cmp_val = 8'h0D;
    send(8'h0D, 0, 1, 1, "R10"); idle(6, 1'b1, "R10");
    send(8'h00, 0, 0, 0, "R6"); idle(24, 1'b0, "R6"); idle(6, 1'b1, "R6");
    send(8'h30, 0, 1, 1, "R10"); idle(6, 1'b1, "R10");
    send(8'h0D, 0, 1, 1, "R10"); idle(6, 1'b1, "R10");
    send(8'h00, 0, 0, 0, "R6"); idle(6, 1'b1, "R6");
    send(8'h0D, 0, 1, 1, "R10"); idle(6, 1'b1, "R10");
    send(8'h0D, 0, 1, 1, "R10"); idle(6, 1'b1, "R10");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule